// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block owns the clock-enable pin of a DDR SDRAM and the command slots used for housekeeping. A free-running interval timer marks each average refresh period. Every mark adds one to a count of owed refreshes. The block pays that debt with auto-refresh commands whenever the traffic scheduler leaves the bus free. While the scheduler is busy, the debt grows. Once the debt reaches a set limit, the block takes the bus away from the scheduler and refreshes anyway. Before any refresh or self-refresh entry, all banks must be idle. If the scheduler reports an open bank, the block first closes every bank with a precharge-all command.

A host can ask for self-refresh or power-down by holding a request line. The block answers with a low-power indication while the clock enable is low. During self-refresh the interval timer is held and the owed count is cleared, because the device refreshes itself. When self-refresh ends, the timer restarts from zero. Leaving self-refresh sets two separate holds: a short one before any command other than a read, and a much longer one before a read. Power-down needs one cycle to enter and one cycle to exit. If the owed count reaches its limit during power-down, the block wakes the device to refresh it and then goes back to power-down.

The grant output tells the scheduler when it may use the current command slot. A second output tells it when reads are allowed.

Top module: `sdref_sequencer`

## Requirements
- R1: After reset the outputs are as follows: `cke_o` is 1, `cmd_o` is 2'b00 (no operation), `sched_gnt_o` is 1, `read_ok_o` is 1 and `lowpwr_o` is 0. The command codes are 2'b01 for precharge-all and 2'b10 for auto-refresh.
- R2: While the scheduler does not request the bus and all banks are idle, consecutive auto-refresh commands are exactly REF_INTERVAL cycles apart.
- R3: While `sched_req_i` is held high, refresh is postponed until MAX_BACKLOG refreshes are owed. At that point the grant is withdrawn and one refresh is issued per interval. No refresh is issued before that point.
- R4: After an auto-refresh, no command is issued and no grant is given for TRFC_CYC-1 cycles. The grant returns exactly TRFC_CYC cycles after the refresh.
- R5: If `banks_open_i` is high when a refresh begins, a precharge-all is issued first. The refresh follows exactly TRP_CYC cycles later.
- R6: Self-refresh is entered by an auto-refresh code in the same cycle that `cke_o` first goes low. After that cycle, no command is issued while `cke_o` is low. While self-refresh lasts, no refresh is owed or issued.
- R7: On leaving self-refresh, the grant returns exactly TXSNR_CYC cycles after `cke_o` rises. `read_ok_o` returns exactly TXSRD_CYC cycles after `cke_o` rises. `read_ok_o` is never high without the grant.
- R8: A power-down request that is accepted drives `cke_o` low in the next cycle, with no command. After the request is released, `cke_o` is high for one cycle before the grant returns. `lowpwr_o` is high only while `cke_o` is low.
- R9: Each time `cke_o` goes low, it stays low for at least CKE_MIN_CYC cycles.
- R10: If MAX_BACKLOG refreshes become owed during power-down, the block leaves power-down, pays the whole debt, and then goes back to power-down while the request is still held.
- R11: The grant is given only in a cycle with `cke_o` high and no command from this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sched_req_i | input | 1 | Traffic scheduler wants the current command slot |
| banks_open_i | input | 1 | At least one bank is open |
| sr_req_i | input | 1 | Host asks for self-refresh (level) |
| pd_req_i | input | 1 | Host asks for power-down (level) |
| cke_o | output | 1 | Clock enable to the device |
| cmd_o | output | 2 | Housekeeping command: 00 none, 01 precharge-all, 10 auto-refresh |
| sched_gnt_o | output | 1 | Scheduler may issue a non-read command in this slot |
| read_ok_o | output | 1 | Scheduler may issue a read in this slot |
| lowpwr_o | output | 1 | Device is held in self-refresh or power-down |

## Verification
The assertions assume two things about the environment. First, the scheduler drops `banks_open_i` once a precharge-all has been issued. Second, the scheduler uses a slot only when it is granted; the checks watch only this block's own outputs. Host requests are treated as plain levels, so the properties allow them to change in any cycle. The stimulus raises and lowers requests only at falling clock edges. It clears `banks_open_i` right after it sees the precharge-all. Each scenario starts from a fresh reset, so the cycle distances the bench expects are counted from known points in the timer.

// File: rtl/sdref_pkg.sv
package sdref_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_PREA = 2'b01,
    CMD_REF  = 2'b10
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PREA, ST_PRE_WAIT, ST_REF, ST_RFC_WAIT,
    ST_SRE, ST_SR, ST_SRX, ST_PD, ST_PDX
  } state_e;
endpackage

// File: rtl/sdref_tick_timer.sv
module sdref_tick_timer #(
  parameter int PERIOD = 390
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pause_i,
  output logic tick_o
);
  localparam int W = $clog2(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  // pause holds the count at zero so the period restarts on resume
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (pause_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !pause_i && (cnt_q == LAST);
endmodule

// File: rtl/sdref_backlog.sv
module sdref_backlog #(
  parameter int MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic nz_o,
  output logic full_o
);
  localparam int W = $clog2(MAX + 1);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else begin
      case ({inc_i, dec_i})
        2'b10:   if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign nz_o   = (cnt_q != '0);
  assign full_o = (cnt_q == TOP);
endmodule

// File: rtl/sdref_down_cnt.sv
module sdref_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdref_sequencer.sv
module sdref_sequencer
  import sdref_pkg::*;
#(
  parameter int REF_INTERVAL = 390,  // cycles per average refresh period
  parameter int MAX_BACKLOG  = 8,
  parameter int TRFC_CYC     = 4,    // >= 2
  parameter int TRP_CYC      = 2,    // >= 2
  parameter int TXSNR_CYC    = 12,   // >= 1
  parameter int TXSRD_CYC    = 200,
  parameter int CKE_MIN_CYC  = 2     // >= 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sched_req_i,
  input  logic       banks_open_i,
  input  logic       sr_req_i,
  input  logic       pd_req_i,
  output logic       cke_o,
  output logic [1:0] cmd_o,
  output logic       sched_gnt_o,
  output logic       read_ok_o,
  output logic       lowpwr_o
);
  localparam int M1 = (TRFC_CYC > TRP_CYC) ? TRFC_CYC : TRP_CYC;
  localparam int M2 = (TXSNR_CYC > CKE_MIN_CYC) ? TXSNR_CYC : CKE_MIN_CYC;
  localparam int WAIT_MAX = (M1 > M2) ? M1 : M2;
  localparam int WAIT_W = $clog2(WAIT_MAX + 1);
  localparam int RD_W   = $clog2(TXSRD_CYC + 1);

  localparam logic [WAIT_W-1:0] LD_RFC  = WAIT_W'(TRFC_CYC - 2);
  localparam logic [WAIT_W-1:0] LD_TRP  = WAIT_W'(TRP_CYC - 2);
  localparam logic [WAIT_W-1:0] LD_XSNR = WAIT_W'(TXSNR_CYC - 1);
  localparam logic [WAIT_W-1:0] LD_PD   = WAIT_W'(CKE_MIN_CYC - 1);
  localparam logic [WAIT_W-1:0] LD_SR   = WAIT_W'(CKE_MIN_CYC - 2);
  localparam logic [RD_W-1:0]   LD_RD   = RD_W'(TXSRD_CYC);

  state_e state_q, state_d;
  logic   goal_sr_q, goal_sr_d;
  cmd_e   cmd;
  logic   wait_ld, rd_ld, wait_zero, rd_zero;
  logic [WAIT_W-1:0] wait_val;
  logic   tick, bl_nz, bl_full, bl_dec, bl_clr, pause;

  assign pause = (state_q == ST_SRE) || (state_q == ST_SR);

  sdref_tick_timer #(.PERIOD(REF_INTERVAL)) u_timer (
    .clk_i, .rst_ni, .pause_i(pause), .tick_o(tick)
  );

  sdref_backlog #(.MAX(MAX_BACKLOG)) u_backlog (
    .clk_i, .rst_ni, .inc_i(tick), .dec_i(bl_dec), .clr_i(bl_clr),
    .nz_o(bl_nz), .full_o(bl_full)
  );

  sdref_down_cnt #(.W(WAIT_W)) u_wait (
    .clk_i, .rst_ni, .load_i(wait_ld), .val_i(wait_val), .zero_o(wait_zero)
  );

  sdref_down_cnt #(.W(RD_W)) u_rd_hold (
    .clk_i, .rst_ni, .load_i(rd_ld), .val_i(LD_RD), .zero_o(rd_zero)
  );

  always_comb begin
    state_d   = state_q;
    goal_sr_d = goal_sr_q;
    cmd       = CMD_NOP;
    wait_ld   = 1'b0;
    wait_val  = '0;
    rd_ld     = 1'b0;
    bl_dec    = 1'b0;
    bl_clr    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        // priority: forced refresh, scheduler, self-refresh, owed refresh, power-down
        if (bl_full || (!sched_req_i && (sr_req_i || bl_nz))) begin
          goal_sr_d = !bl_full && sr_req_i;
          if (banks_open_i)   state_d = ST_PREA;
          else if (goal_sr_d) state_d = ST_SRE;
          else                state_d = ST_REF;
        end else if (!sched_req_i && pd_req_i) begin
          state_d  = ST_PD;
          wait_ld  = 1'b1;
          wait_val = LD_PD;
        end
      end
      ST_PREA: begin
        cmd      = CMD_PREA;
        state_d  = ST_PRE_WAIT;
        wait_ld  = 1'b1;
        wait_val = LD_TRP;
      end
      ST_PRE_WAIT: if (wait_zero) state_d = goal_sr_q ? ST_SRE : ST_REF;
      ST_REF: begin
        cmd      = CMD_REF;
        bl_dec   = 1'b1;
        state_d  = ST_RFC_WAIT;
        wait_ld  = 1'b1;
        wait_val = LD_RFC;
      end
      ST_RFC_WAIT: if (wait_zero) state_d = ST_IDLE;
      ST_SRE: begin
        cmd      = CMD_REF;  // refresh code with clock enable low
        bl_clr   = 1'b1;
        state_d  = ST_SR;
        wait_ld  = 1'b1;
        wait_val = LD_SR;
      end
      ST_SR: if (wait_zero && !sr_req_i) begin
        state_d  = ST_SRX;
        wait_ld  = 1'b1;
        wait_val = LD_XSNR;
        rd_ld    = 1'b1;
      end
      ST_SRX: if (wait_zero) state_d = ST_IDLE;
      ST_PD: if (wait_zero && (!pd_req_i || bl_full)) state_d = ST_PDX;
      ST_PDX: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      goal_sr_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      goal_sr_q <= goal_sr_d;
    end
  end

  assign cke_o       = !((state_q == ST_SRE) || (state_q == ST_SR) || (state_q == ST_PD));
  assign lowpwr_o    = (state_q == ST_SR) || (state_q == ST_PD);
  assign cmd_o       = cmd;
  assign sched_gnt_o = (state_q == ST_IDLE) && !bl_full;
  assign read_ok_o   = sched_gnt_o && rd_zero;
endmodule

// File: rtl/sdref_sequencer_chk.sv
module sdref_sequencer_chk #(
  parameter int TRFC_CYC    = 4,
  parameter int TXSNR_CYC   = 12,
  parameter int TXSRD_CYC   = 200,
  parameter int CKE_MIN_CYC = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cke_o,
  input logic [1:0] cmd_o,
  input logic       sched_gnt_o,
  input logic       read_ok_o,
  input logic       lowpwr_o
);
  localparam logic [1:0] NOP = 2'b00;
  localparam logic [1:0] REF = 2'b10;

  int   since_ref, low_len, since_srx;
  logic cke_q, sr_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_ref <= TRFC_CYC;
      low_len   <= 0;
      since_srx <= TXSRD_CYC;
      cke_q     <= 1'b1;
      sr_flag   <= 1'b0;
    end else begin
      cke_q <= cke_o;
      if (cmd_o == REF && cke_o)   since_ref <= 1;
      else if (since_ref < TRFC_CYC) since_ref <= since_ref + 1;
      if (cke_o)                     low_len <= 0;
      else if (low_len < CKE_MIN_CYC) low_len <= low_len + 1;
      if (!cke_o && cmd_o == REF) sr_flag <= 1'b1;
      if (cke_o && !cke_q && sr_flag) begin
        since_srx <= 1;
        sr_flag   <= 1'b0;
      end else if (since_srx < TXSRD_CYC) begin
        since_srx <= since_srx + 1;
      end
    end
  end

  assert_grant_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sched_gnt_o |-> (cke_o && cmd_o == NOP));
  assert_read_needs_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_ok_o |-> sched_gnt_o);
  assert_low_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && cmd_o != NOP) |-> (cke_q && cmd_o == REF));
  assert_rfc_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_ref < TRFC_CYC) |-> (!sched_gnt_o && cmd_o == NOP));
  assert_cke_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && !cke_q) |-> (low_len >= CKE_MIN_CYC));
  assert_xsnr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_srx < TXSNR_CYC) |-> !sched_gnt_o);
  assert_xsrd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_srx < TXSRD_CYC) |-> !read_ok_o);
  assert_lowpwr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr_o |-> !cke_o);
endmodule

bind sdref_sequencer sdref_sequencer_chk #(
  .TRFC_CYC(TRFC_CYC), .TXSNR_CYC(TXSNR_CYC),
  .TXSRD_CYC(TXSRD_CYC), .CKE_MIN_CYC(CKE_MIN_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_o(cke_o), .cmd_o(cmd_o),
  .sched_gnt_o(sched_gnt_o), .read_ok_o(read_ok_o), .lowpwr_o(lowpwr_o)
);

// File: tb/sim_sdref_sequencer.sv
module sim_sdref_sequencer;
  localparam int IVL = 60, MAXB = 3, TRFC = 4, TRP = 2, TXSNR = 12, TXSRD = 200, CKEMIN = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sched_req_i = 0, banks_open_i = 0, sr_req_i = 0, pd_req_i = 0;
  logic cke_o, sched_gnt_o, read_ok_o, lowpwr_o;
  logic [1:0] cmd_o;

  sdref_sequencer #(
    .REF_INTERVAL(IVL), .MAX_BACKLOG(MAXB), .TRFC_CYC(TRFC), .TRP_CYC(TRP),
    .TXSNR_CYC(TXSNR), .TXSRD_CYC(TXSRD), .CKE_MIN_CYC(CKEMIN)
  ) u0 (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  int cyc = 0, checks = 0, fails = 0;
  int ref_cnt, prea_cnt, sre_cnt, last_ref, prev_ref, first_ref, last_prea;
  int last_rise, last_fall, last_gnt_rise, rel_cyc;
  int gnt_after, rd_after, ref_after;
  bit gnt_seen, rd_seen, ref_seen, cke_p, gnt_p, rd_p;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  always @(negedge clk_i) if (rst_ni) begin
    if (cmd_o == 2'b10 && cke_o) begin
      ref_cnt++;
      if (ref_cnt == 1) first_ref = cyc;
      prev_ref = last_ref; last_ref = cyc;
      if (!ref_seen) begin ref_after = cyc; ref_seen = 1; end
    end
    if (cmd_o == 2'b01) begin prea_cnt++; last_prea = cyc; end
    if (cmd_o == 2'b10 && !cke_o) sre_cnt++;
    if (cke_o && !cke_p) begin
      last_rise = cyc; gnt_seen = 0; rd_seen = 0; ref_seen = 0;
    end
    if (!cke_o && cke_p) last_fall = cyc;
    if (sched_gnt_o && !gnt_p) begin
      last_gnt_rise = cyc;
      if (!gnt_seen) begin gnt_after = cyc; gnt_seen = 1; end
    end
    if (read_ok_o && !rd_p && !rd_seen) begin rd_after = cyc; rd_seen = 1; end
    cke_p = cke_o; gnt_p = sched_gnt_o; rd_p = read_ok_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_reset(input logic sreq, input logic bopen, input logic pdr);
    @(negedge clk_i);
    rst_ni = 0; sched_req_i = sreq; banks_open_i = bopen; sr_req_i = 0; pd_req_i = pdr;
    ref_cnt = 0; prea_cnt = 0; sre_cnt = 0; last_ref = 0; prev_ref = 0; first_ref = 0;
    last_prea = 0; last_rise = 0; last_fall = 0; last_gnt_rise = 0;
    gnt_seen = 1; rd_seen = 1; ref_seen = 1; cke_p = 1; gnt_p = 1; rd_p = 1;
    wait_n(3);
    rst_ni = 1; rel_cyc = cyc;
  endtask

  task automatic t_reset;
    do_reset(0, 0, 0);
    chk_eq("R1 cke", cke_o, 1);
    chk_eq("R1 cmd", cmd_o, 0);
    chk_eq("R1 gnt", sched_gnt_o, 1);
    chk_eq("R1 read_ok", read_ok_o, 1);
    chk_eq("R1 lowpwr", lowpwr_o, 0);
  endtask

  task automatic t_periodic;
    do_reset(0, 0, 0);
    for (int g = 0; g < 1000 && ref_cnt < 3; g++) @(negedge clk_i);
    chk_eq("R2 refresh spacing", last_ref - prev_ref, IVL);
    wait_n(8);
    chk_eq("R4 grant after refresh", last_gnt_rise - last_ref, TRFC);
  endtask

  task automatic t_forced;
    do_reset(1, 0, 0);
    for (int g = 0; g < 1000 && ref_cnt < 1; g++) @(negedge clk_i);
    chk(ref_cnt == 1, "R3 forced refresh issued", ref_cnt, 1);
    chk(first_ref - rel_cyc > (MAXB - 1) * IVL + IVL / 2 && first_ref - rel_cyc <= MAXB * IVL + 5,
        "R3 refresh held until backlog full", first_ref - rel_cyc, MAXB * IVL);
    for (int g = 0; g < 1000 && ref_cnt < 2; g++) @(negedge clk_i);
    chk_eq("R3 spacing while busy", last_ref - prev_ref, IVL);
    sched_req_i = 0;
  endtask

  task automatic t_prea;
    do_reset(0, 1, 0);
    for (int g = 0; g < 1000 && prea_cnt < 1; g++) @(negedge clk_i);
    banks_open_i = 0;
    for (int g = 0; g < 100 && ref_cnt < 1; g++) @(negedge clk_i);
    chk_eq("R5 precharge count", prea_cnt, 1);
    chk_eq("R5 precharge to refresh", last_ref - last_prea, TRP);
  endtask

  task automatic t_selfref;
    int refs;
    do_reset(0, 0, 0);
    for (int g = 0; g < 1000 && ref_cnt < 1; g++) @(negedge clk_i);
    wait_n(10);
    sr_req_i = 1;
    for (int g = 0; g < 100 && sre_cnt < 1; g++) @(negedge clk_i);
    chk_eq("R6 entry with cke low", sre_cnt, 1);
    wait_n(3);
    chk_eq("R6 lowpwr held", lowpwr_o, 1);
    refs = ref_cnt;
    wait_n(250);
    chk_eq("R6 no refresh in self-refresh", ref_cnt, refs);
    chk_eq("R6 cke low in self-refresh", cke_o, 0);
    sr_req_i = 0;
    for (int g = 0; g < 100 && !cke_o; g++) @(negedge clk_i);
    wait_n(215);
    chk_eq("R7 non-read wait", gnt_after - last_rise, TXSNR);
    chk_eq("R7 read wait", rd_after - last_rise, TXSRD);
    chk_eq("R6 timer restarted", ref_after - last_rise, IVL + 1);
  endtask

  task automatic t_pd;
    do_reset(0, 0, 0);
    wait_n(2);
    pd_req_i = 1;
    @(negedge clk_i);
    chk_eq("R8 cke low after request", cke_o, 0);
    chk_eq("R8 no command on entry", cmd_o, 0);
    pd_req_i = 0;
    wait_n(10);
    chk_eq("R9 cke low length", last_rise - last_fall, CKEMIN);
    chk_eq("R8 exit to grant", last_gnt_rise - last_rise, 1);
  endtask

  task automatic t_pd_force;
    do_reset(0, 0, 1);
    for (int g = 0; g < 1000 && ref_cnt < 1; g++) @(negedge clk_i);
    chk(first_ref - rel_cyc > (MAXB - 1) * IVL + IVL / 2 && first_ref - rel_cyc <= MAXB * IVL + 8,
        "R10 wake for forced refresh", first_ref - rel_cyc, MAXB * IVL + 4);
    wait_n(40);
    chk_eq("R10 backlog paid", ref_cnt, MAXB);
    chk_eq("R10 back in power-down", lowpwr_o, 1);
    pd_req_i = 0;
  endtask

  initial begin
    t_reset();
    t_periodic();
    t_forced();
    t_prea();
    t_selfref();
    t_pd();
    t_pd_force();
    wait_n(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule